// File: doc/BRIEF.md
# Suffix-Keyed Serial Debug Port

This block is a small serial access port for reaching into a core from a debug host. It uses four pins: a clock, a serial data input, an active-low write strobe and a serial data output. While the strobe is held low, every clock edge shifts one bit into a 40-bit chain, most significant bit first. The host sends a 32-bit payload followed by an 8-bit key byte. When the strobe goes back high, the chain stops moving and the key byte that is now resident at the low end of the chain is decoded.

Each recognised key selects one 8-bit group of persistent control cells, and only that group takes its slice of the payload. The default build knows four keys, each an ASCII letter: 'T' (0x54) for test, 'E' (0x45) for events, 'R' (0x52) for registers and 'O' (0x4F) for outputs. A key that is not recognised changes no persistent state, but its bits stay in the chain. The chain bits themselves are also exposed as transient outputs that follow every shift. The last accepted key is kept as a control word that drives auxiliary multiplexer selects.

The top of the chain drives the serial output. While the next frame is shifted in, the previous frame therefore comes back out, key byte included, so the host can verify the link by loopback.

Top module: `skd_port`

## Requirements
- R1: While `wr_n` is low, each rising clock edge shifts `sdi` into the chain, most significant bit first. `sdo` is the top chain bit, so `sdo` repeats the bit that entered 40 shifts earlier. During the next frame the previous 40-bit frame comes out unchanged.
- R2: While `wr_n` is high, the chain holds its contents whatever `sdi` does. `scan_q` and `sdo` stay constant.
- R3: With key 0x54 ('T'), the first rising edge that sees `wr_n` high copies payload bits [7:0] into `grp_q[7:0]`. For example, payload 0xFFFFFFFF followed by 'T' makes `grp_q[7:0]` equal to 0xFF.
- R4: The other keys each write only their own slice on that edge: key 0x45 ('E') writes bits [15:8], key 0x52 ('R') writes bits [23:16] and key 0x4F ('O') writes bits [31:24]. All other slices keep their values.
- R5: Any other key byte, for example 0x42, changes neither `grp_q` nor `sel_q`.
- R6: While `rst_n` is low, `grp_q` and `sel_q` are cleared to zero.
- R7: `grp_q` holds its value while a new frame is being shifted in (`wr_n` low).
- R8: `scan_q` equals the 32 payload bits now in the chain (the frame bits 39..8) for any key, recognised or not.
- R9: `sel_q` takes the key byte on every accepted write and is left unchanged by an unknown key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial shift clock |
| rst_n | input | 1 | Active-low reset for the persistent cells and the control word |
| sdi | input | 1 | Serial data in, most significant bit first |
| wr_n | input | 1 | Low: shift. High: decode the key and write the selected group |
| sdo | output | 1 | Top chain bit, used as the loopback output |
| grp_q | output | 32 | Persistent group cells, group k in bits [8k+7:8k] |
| scan_q | output | 32 | Transient payload bits of the chain |
| sel_q | output | 8 | Last accepted key, used as the auxiliary select word |

## Verification
A bit driven on `sdi` appears in `scan_q` after the next rising edge. It reaches `sdo` once 39 further shifts have passed, and the bench samples it at the falling edge before the matching bit of the next frame is driven. The group and select writes are due one rising edge after `wr_n` rises. The driver raises the strobe at a falling edge and lets exactly one rising edge pass. It then pushes the expected group, select and scan values into a queue, and the monitor compares them at the following falling edge. Hold behaviour is sampled in the middle of a later frame and during idle cycles with the strobe high, always at falling edges.

// File: rtl/skd_pkg.sv
package skd_pkg;
  localparam int KEY_W   = 8;
  localparam int MAX_GRP = 8;
  typedef logic [KEY_W-1:0] key_t;
  // Group k answers to KEY_TAB[k]; entries beyond the group count stay unused.
  localparam key_t KEY_TAB [MAX_GRP] = '{8'h54, 8'h45, 8'h52, 8'h4F,
                                          8'h42, 8'h43, 8'h49, 8'h4C};
endpackage

// File: rtl/skd_shift_chain.sv
module skd_shift_chain #(
  parameter int LEN = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_n,
  input  logic           sdi,
  output logic [LEN-1:0] chain,
  output logic           sdo
);
  // Transient cells: one flop each, no reset needed.
  always_ff @(posedge clk) begin
    if (!wr_n) chain <= {chain[LEN-2:0], sdi};
  end

  assign sdo = chain[LEN-1];

  // R2: strobe high freezes the chain
  a_r2_chain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |=> $stable(chain));
endmodule

// File: rtl/skd_key_decode.sv
module skd_key_decode
  import skd_pkg::*;
#(
  parameter int N_GRP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  key_t             key,
  output logic [N_GRP-1:0] hit
);
  always_comb begin
    for (int k = 0; k < N_GRP; k++) hit[k] = (key == KEY_TAB[k]);
  end

  // R4: at most one group is ever selected
  a_r4_single_group: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/skd_latch_bank.sv
module skd_latch_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         hit,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  // Persistent cells: they load while the strobe is high and this group is keyed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            q <= '0;
    else if (wr_n && hit)  q <= din;
  end

  // R7: shifting never disturbs stored values
  a_r7_hold_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> $stable(q));
  // R5: a group that is not keyed keeps its value
  a_r5_unkeyed_group_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(q));
endmodule

// File: rtl/skd_port.sv
module skd_port
  import skd_pkg::*;
#(
  parameter int GRP_W = 8,
  parameter int N_GRP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdi,
  input  logic                   wr_n,
  output logic                   sdo,
  output logic [N_GRP*GRP_W-1:0] grp_q,
  output logic [N_GRP*GRP_W-1:0] scan_q,
  output logic [KEY_W-1:0]       sel_q
);
  localparam int PAY_W = N_GRP * GRP_W;
  localparam int LEN   = PAY_W + KEY_W;

  logic [LEN-1:0]   chain;
  logic [N_GRP-1:0] hit;
  key_t             key;

  skd_shift_chain #(.LEN(LEN)) u_chain (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sdi(sdi), .chain(chain), .sdo(sdo)
  );

  assign key    = chain[KEY_W-1:0];
  assign scan_q = chain[LEN-1:KEY_W];

  skd_key_decode #(.N_GRP(N_GRP)) u_dec (
    .clk(clk), .rst_n(rst_n), .key(key), .hit(hit)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_bank
    skd_latch_bank #(.W(GRP_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .hit(hit[g]),
      .din(scan_q[g*GRP_W +: GRP_W]), .q(grp_q[g*GRP_W +: GRP_W])
    );
  end

  // Control word for auxiliary multiplexer selects
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              sel_q <= '0;
    else if (wr_n && |hit)   sel_q <= key;
  end

  // R9: the control word only moves after an accepted write
  a_r9_sel_needs_valid_key: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(wr_n && (|hit)));
endmodule

// File: tb/sim_skd_port.sv
`timescale 1ns/1ps
module sim_skd_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        wr_n = 1'b1;
  logic        sdo;
  logic [31:0] grp_q, scan_q;
  logic [7:0]  sel_q;

  always #2.5 clk = ~clk;

  skd_port u0 (.clk(clk), .rst_n(rst_n), .sdi(sdi), .wr_n(wr_n), .sdo(sdo),
               .grp_q(grp_q), .scan_q(scan_q), .sel_q(sel_q));

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [31:0] grp;
    logic [7:0]  sel;
    logic [31:0] scan;
  } exp_t;
  exp_t sb_q[$];
  event mon_ev;

  logic [31:0] m_grp = '0;
  logic [7:0]  m_sel = '0;
  logic [39:0] prev_frame;
  bit          have_prev = 0;

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected results and compares them with the outputs.
  always @(mon_ev) begin
    exp_t e;
    e = sb_q.pop_front();
    chk(grp_q == e.grp, "R3/R4/R5 group cells", {8'h0, grp_q}, {8'h0, e.grp});
    chk(sel_q == e.sel, "R9 select word", {32'h0, sel_q}, {32'h0, e.sel});
    chk(scan_q == e.scan, "R8 transient cells", {8'h0, scan_q}, {8'h0, e.scan});
  end

  task automatic send_frame(input logic [31:0] pay, input logic [7:0] key);
    logic [39:0] f;
    bit echo_ok;
    logic [39:0] echo;
    f = {pay, key};
    echo_ok = 1;
    echo = '0;
    for (int i = 39; i >= 0; i--) begin
      @(negedge clk);
      echo[i] = sdo;
      if (i == 20)
        chk(grp_q == m_grp, "R7 hold during shift", {8'h0, grp_q}, {8'h0, m_grp});
      wr_n = 1'b0;
      sdi  = f[i];
    end
    @(negedge clk);
    wr_n = 1'b1;
    sdi  = 1'b0;
    if (have_prev)
      chk(echo == prev_frame, "R1 loopback echo", echo, prev_frame);
    prev_frame = f;
    have_prev  = 1;
    // Model of the key decode.
    case (key)
      8'h54: begin m_grp[7:0]   = pay[7:0];   m_sel = key; end
      8'h45: begin m_grp[15:8]  = pay[15:8];  m_sel = key; end
      8'h52: begin m_grp[23:16] = pay[23:16]; m_sel = key; end
      8'h4F: begin m_grp[31:24] = pay[31:24]; m_sel = key; end
      default: ;
    endcase
    sb_q.push_back('{grp: m_grp, sel: m_sel, scan: pay});
    @(negedge clk);
    -> mon_ev;
    #0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(grp_q == 32'h0, "R6 reset groups", {8'h0, grp_q}, 40'h0);
    chk(sel_q == 8'h0, "R6 reset select", {32'h0, sel_q}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);

    send_frame(32'hFFFF_FFFF, 8'h54);   // R3 example: all ones into T
    send_frame(32'h1234_5678, 8'h45);   // R4 E slice
    send_frame(32'hA5C3_9F01, 8'h52);   // R4 R slice
    send_frame(32'h6E00_00AA, 8'h4F);   // R4 O slice
    send_frame(32'h0000_0000, 8'h42);   // R5 unknown key, bits stay in chain
    send_frame(32'hDEAD_BEEF, 8'h00);   // R5 unknown key
    send_frame(32'h0F0F_0F0F, 8'h54);   // R3 again, other slices hold

    // R2: strobe high, sdi toggling, chain must not move
    begin
      logic [31:0] s0;
      logic        o0;
      s0 = scan_q;
      o0 = sdo;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        sdi = ~sdi;
      end
      @(negedge clk);
      chk(scan_q == s0, "R2 chain frozen", {8'h0, scan_q}, {8'h0, s0});
      chk(sdo == o0, "R2 sdo frozen", {39'h0, sdo}, {39'h0, o0});
    end

    send_frame(32'h1357_9BDF, 8'h4F);   // R1 echo of previous frame plus R4

    // R6: reset mid-operation clears the persistent state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(grp_q == 32'h0, "R6 reset groups", {8'h0, grp_q}, 40'h0);
    chk(sel_q == 8'h0, "R6 reset select", {32'h0, sel_q}, 40'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule